// File: doc/BRIEF.md
# SPI Master with Programmable Frame Delays

This block is an SPI master engine running in clock mode 3. It takes words from a valid/ready transmit port, shifts each out on MOSI most significant bit first while shifting the same number of bits in from MISO, and returns the received word on an output with a single-cycle valid strobe. It drives SCK and one active-low chip select. Each frame may be from 1 to `DATA_W` bits long.

All timing is counted in prescaled clock ticks. A power-of-two prescaler turns the functional clock into ticks. Configuration fields then set four things: the SCK period, the delay from chip select to the first SCK edge, the delay from the last SCK edge to chip select release, and the idle gap before chip select may fall again. Each field uses an offset encoding, so every delay is at least one tick.

A continuous mode keeps chip select low across frames. While it is set, a word that is waiting at the final capture edge starts the next frame one SCK period later. No release, trail delay or gap is inserted. The configuration inputs are static while the engine is busy.

Top module: `spi_delay_master`

## Requirements
- R1: SCK rests high whenever chip select is high. MOSI changes only on a falling (leading) SCK edge. MISO is sampled on the rising (trailing) SCK edge.
- R2: A frame carries `cfg_frame_len_i`+1 bits. Words are right-aligned: transmit bit `cfg_frame_len_i` goes out first and bit 0 goes out last. The received word holds the first sampled bit at bit `cfg_frame_len_i`, and its upper bits are zero.
- R3: One tick equals 2^`cfg_prescale_i` functional clocks. The SCK period is (`cfg_sck_div_i`+2) ticks, and this includes the periods that span a frame boundary in continuous mode.
- R4: From chip select falling to the first SCK falling edge takes (`cfg_lead_dly_i`+1) ticks.
- R5: From the last SCK rising edge of a frame to chip select rising takes (`cfg_trail_dly_i`+1) ticks.
- R6: When a word is already waiting, chip select stays high for exactly (`cfg_gap_dly_i`+2) ticks between frames.
- R7: Chip select is active low. With `cfg_cont_i`=0 it is released after every frame, even when the next word is already waiting.
- R8: With `cfg_cont_i`=1 and a word waiting at the last capture edge, chip select stays low and the next frame follows without a trail delay or a gap.
- R9: `rx_valid_o` is high for exactly one clock per frame. That clock is the one in which SCK rises for the final capture of the frame.
- R10: After chip select is released, MOSI keeps the last bit it drove.
- R11: During and after reset: `cs_no`=1, `sck_o`=1, `mosi_o`=0, `busy_o`=0, `rx_valid_o`=0, `tx_ready_o`=1.
- R12: A word is taken on a clock where `tx_valid_i` and `tx_ready_o` are both high. `busy_o` then stays high until the gap after the last frame has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_prescale_i | input | PRE_W | Tick = 2^value clocks |
| cfg_sck_div_i | input | DIV_W | SCK period = value+2 ticks |
| cfg_lead_dly_i | input | DLY_W | Select-to-SCK delay = value+1 ticks |
| cfg_trail_dly_i | input | DLY_W | SCK-to-release delay = value+1 ticks |
| cfg_gap_dly_i | input | DLY_W | Inter-frame gap = value+2 ticks |
| cfg_frame_len_i | input | IDX_W | Bits per frame minus one |
| cfg_cont_i | input | 1 | Keep select low across back-to-back frames |
| tx_data_i | input | DATA_W | Word to send, right-aligned |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Transmit word accepted this clock |
| rx_data_o | output | DATA_W | Last received word, right-aligned |
| rx_valid_o | output | 1 | One-clock strobe for a new received word |
| busy_o | output | 1 | Engine active |
| sck_o | output | 1 | Serial clock, idles high |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench measures every delay in clocks from pin transitions. It uses settings at both extremes: a 1-bit frame, the 2-tick minimum SCK period with all delay fields at zero, odd periods, and a full-width frame. An off-by-one in any offset encoding, or a prescaler that does not restart when the engine wakes, shows up as a lead, trail, gap or period that is one tick or one clock wrong. A design that inserts an idle clock between the gap and the next frame shows up as a gap one clock too long. A continuous-mode pair must show a single select window of double length, with a uniform period across the boundary. A design that releases select there, or loses a bit at the reload, fails on the select count or on the received words. The bench also checks that MOSI holds the final bit after release, which catches a data line that is reset to zero when select rises.

// File: rtl/spi_dm_pkg.sv
package spi_dm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL,
    ST_GAP
  } spi_state_e;
endpackage

// File: rtl/spi_dm_prescaler.sv
module spi_dm_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int PC_W = (1 << PRE_W) - 1;

  logic [PC_W-1:0] cnt_q;
  logic [PC_W-1:0] lim;

  assign lim    = PC_W'((32'd1 << exp_i) - 32'd1);
  assign tick_o = en_i && (cnt_q == lim);

  // restarts on wake so delays are counted from the select edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PC_W'(1);
  end
endmodule

// File: rtl/spi_dm_timer.sv
module spi_dm_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= val_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/spi_dm_shifter.sv
module spi_dm_shifter #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic              launch_i,
  input  logic              capture_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_next_o,
  output logic              last_o
);
  logic [DATA_W-1:0] tx_q, rx_q;
  logic [IDX_W-1:0]  idx_q;

  assign last_o    = (idx_q == '0);
  assign rx_next_o = {rx_q[DATA_W-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      idx_q  <= '0;
      mosi_o <= 1'b0;
    end else begin
      if (launch_i) mosi_o <= tx_q[idx_q];
      // a reload on the final capture takes priority
      if (load_i) begin
        tx_q  <= data_i;
        idx_q <= len_i;
        rx_q  <= '0;
      end else if (capture_i) begin
        rx_q <= rx_next_o;
        if (idx_q != '0) idx_q <= idx_q - IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_delay_master.sv
module spi_delay_master #(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 3,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRE_W-1:0]  cfg_prescale_i,
  input  logic [DIV_W-1:0]  cfg_sck_div_i,
  input  logic [DLY_W-1:0]  cfg_lead_dly_i,
  input  logic [DLY_W-1:0]  cfg_trail_dly_i,
  input  logic [DLY_W-1:0]  cfg_gap_dly_i,
  input  logic [IDX_W-1:0]  cfg_frame_len_i,
  input  logic              cfg_cont_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  import spi_dm_pkg::*;

  localparam int CNT_W = ((DIV_W > DLY_W) ? DIV_W : DLY_W) + 1;

  spi_state_e        st_q, st_d;
  logic              cs_d, sck_d, rxv_d;
  logic              tick, done, last;
  logic              ld_en, load_word, launch, capture;
  logic [CNT_W-1:0]  ld_val, period, low_len, high_len;
  logic [DATA_W-1:0] rx_next, rx_q;

  assign period   = CNT_W'(cfg_sck_div_i) + CNT_W'(2);
  assign low_len  = period >> 1;
  assign high_len = period - low_len;
  assign busy_o   = (st_q != ST_IDLE);

  spi_dm_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk_i, .rst_ni, .en_i(busy_o), .exp_i(cfg_prescale_i), .tick_o(tick)
  );

  spi_dm_timer #(.CNT_W(CNT_W)) i_tmr (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(ld_en), .val_i(ld_val), .done_o(done)
  );

  spi_dm_shifter #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_shf (
    .clk_i, .rst_ni, .load_i(load_word), .data_i(tx_data_i), .len_i(cfg_frame_len_i),
    .launch_i(launch), .capture_i(capture), .miso_i, .mosi_o, .rx_next_o(rx_next),
    .last_o(last)
  );

  always_comb begin
    st_d = st_q; cs_d = cs_no; sck_d = sck_o; rxv_d = 1'b0;
    tx_ready_o = 1'b0; load_word = 1'b0; launch = 1'b0; capture = 1'b0;
    ld_en = 1'b0; ld_val = '0;
    unique case (st_q)
      ST_IDLE: begin
        tx_ready_o = 1'b1;
        if (tx_valid_i) begin
          load_word = 1'b1; cs_d = 1'b0; st_d = ST_LEAD;
          ld_en = 1'b1; ld_val = CNT_W'(cfg_lead_dly_i);
        end
      end
      ST_LEAD, ST_HIGH: if (done) begin
        launch = 1'b1; sck_d = 1'b0; st_d = ST_LOW;
        ld_en = 1'b1; ld_val = low_len - CNT_W'(1);
      end
      ST_LOW: if (done) begin
        capture = 1'b1; sck_d = 1'b1; ld_en = 1'b1;
        st_d = ST_HIGH; ld_val = high_len - CNT_W'(1);
        if (last) begin
          rxv_d = 1'b1;
          tx_ready_o = cfg_cont_i;
          if (!(cfg_cont_i && tx_valid_i)) begin
            st_d = ST_TRAIL; ld_val = CNT_W'(cfg_trail_dly_i);
          end else begin
            load_word = 1'b1;
          end
        end
      end
      ST_TRAIL: if (done) begin
        cs_d = 1'b1; st_d = ST_GAP;
        ld_en = 1'b1; ld_val = CNT_W'(cfg_gap_dly_i) + CNT_W'(1);
      end
      ST_GAP: if (done) begin
        tx_ready_o = 1'b1;
        st_d = ST_IDLE;
        // a waiting word starts straight from the gap end
        if (tx_valid_i) begin
          load_word = 1'b1; cs_d = 1'b0; st_d = ST_LEAD;
          ld_en = 1'b1; ld_val = CNT_W'(cfg_lead_dly_i);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cs_no      <= 1'b1;
      sck_o      <= 1'b1;
      rx_valid_o <= 1'b0;
      rx_q       <= '0;
    end else begin
      st_q       <= st_d;
      cs_no      <= cs_d;
      sck_o      <= sck_d;
      rx_valid_o <= rxv_d;
      if (rxv_d) rx_q <= rx_next;
    end
  end

  assign rx_data_o = rx_q;
endmodule

// File: rtl/spi_delay_master_chk.sv
module spi_delay_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic busy_o,
  input logic sck_o,
  input logic cs_no,
  input logic mosi_o
);
  // R1
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sck_o);
  // R7
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
  // R9
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R9
  rx_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (sck_o && !$past(sck_o)));
  // R10
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && $past(cs_no)) |-> $stable(mosi_o));
  // R12
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o && !busy_o) |=> (busy_o && !cs_no));
endmodule

bind spi_delay_master spi_delay_master_chk i_chk (
  .clk_i, .rst_ni, .tx_valid_i, .tx_ready_o, .rx_valid_o, .busy_o,
  .sck_o, .cs_no, .mosi_o
);

// File: tb/test_spi_delay_master.sv
module test_spi_delay_master;
  typedef struct packed {
    logic [2:0]  pre;
    logic [7:0]  div;
    logic [7:0]  lead;
    logic [7:0]  trail;
    logic [7:0]  gap;
    logic [3:0]  len;
    logic [15:0] tx;
    logic [15:0] rx;
  } vec_t;

  localparam vec_t VECS [0:3] = '{
    '{3'd2, 8'd8, 8'd4, 8'd4, 8'd8, 4'd15, 16'hA5C3, 16'h3C5A},
    '{3'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'd7,  16'h0081, 16'h007E},
    '{3'd1, 8'd3, 8'd2, 8'd5, 8'd1, 4'd0,  16'h0001, 16'h0001},
    '{3'd3, 8'd1, 8'd7, 8'd0, 8'd3, 4'd11, 16'h05A3, 16'h0C3F}
  };

  logic clk = 0, rst_ni = 0;
  logic [2:0] cfg_prescale_i = 0;
  logic [7:0] cfg_sck_div_i = 0, cfg_lead_dly_i = 0, cfg_trail_dly_i = 0, cfg_gap_dly_i = 0;
  logic [3:0] cfg_frame_len_i = 0;
  logic cfg_cont_i = 0;
  logic [15:0] tx_data_i = 0;
  logic tx_valid_i = 0, miso_i = 0;
  logic tx_ready_o, rx_valid_o, busy_o, sck_o, cs_no, mosi_o;
  logic [15:0] rx_data_o;

  always #4 clk = ~clk;

  spi_delay_master i_spi_delay_master (
    .clk_i(clk), .rst_ni, .cfg_prescale_i, .cfg_sck_div_i, .cfg_lead_dly_i,
    .cfg_trail_dly_i, .cfg_gap_dly_i, .cfg_frame_len_i, .cfg_cont_i,
    .tx_data_i, .tx_valid_i, .tx_ready_o, .rx_data_o, .rx_valid_o, .busy_o,
    .sck_o, .cs_no, .mosi_o, .miso_i
  );

  int n_chk = 0, n_fail = 0;
  int exp_per, exp_lead, exp_trail, exp_gap;
  int cyc = 0, t_csf, t_csr, t_lr, last_fall;
  int per_bad, lead_bad, trail_bad, gap_bad, rxrise_bad;
  int csf_cnt, csr_cnt, rise_cnt, rxv_cnt;
  bit first_pend, gap_armed;
  logic prev_cs = 1, prev_sck = 1;
  logic [31:0] mon_sh, slv_sh, slv_load, mos_last, mos_prev;
  logic [15:0] rx_last, rx_prev;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    per_bad = 0; lead_bad = 0; trail_bad = 0; gap_bad = 0; rxrise_bad = 0;
    csf_cnt = 0; csr_cnt = 0; rise_cnt = 0; rxv_cnt = 0; gap_armed = 0;
  endtask

  // pin monitor and slave model, away from the active edge
  always @(negedge clk) begin
    bit rose;
    cyc++;
    rose = 0;
    if (prev_cs && !cs_no) begin
      csf_cnt++; t_csf = cyc; first_pend = 1; mon_sh = 0; last_fall = -1;
      slv_sh = slv_load;
      if (gap_armed && (cyc - t_csr) != exp_gap) gap_bad++;
      gap_armed = 0;
    end
    if (!prev_cs && cs_no) begin
      csr_cnt++; t_csr = cyc; gap_armed = 1;
      if ((cyc - t_lr) != exp_trail) trail_bad++;
      mos_prev = mos_last; mos_last = mon_sh;
    end
    if (prev_sck && !sck_o && !cs_no) begin
      if (first_pend && (cyc - t_csf) != exp_lead) lead_bad++;
      first_pend = 0;
      if (last_fall >= 0 && (cyc - last_fall) != exp_per) per_bad++;
      last_fall = cyc;
      miso_i = slv_sh[31]; slv_sh = slv_sh << 1;
    end
    if (!prev_sck && sck_o) begin
      mon_sh = {mon_sh[30:0], mosi_o}; t_lr = cyc; rise_cnt++; rose = 1;
    end
    if (rx_valid_o) begin
      rxv_cnt++; rx_prev = rx_last; rx_last = rx_data_o;
      if (!rose) rxrise_bad++;
    end
    prev_cs = cs_no; prev_sck = sck_o;
  end

  task automatic push(logic [15:0] w);
    @(negedge clk);
    tx_data_i = w; tx_valid_i = 1;
    while (!tx_ready_o) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic finish_run();
    @(negedge clk) tx_valid_i = 0;
    do @(negedge clk); while (busy_o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 cs", cs_no, 1); chk("R11 sck", sck_o, 1); chk("R11 mosi", mosi_o, 0);
    chk("R11 busy", busy_o, 0); chk("R11 rxv", rx_valid_o, 0); chk("R11 ready", tx_ready_o, 1);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 4; v++) begin
      vec_t t = VECS[v];
      int tk = 1 << t.pre;
      logic [15:0] mask = 16'((32'd1 << (t.len + 1)) - 1);
      logic [15:0] w1 = t.tx & mask, w2 = ~t.tx & mask;
      cfg_prescale_i = t.pre; cfg_sck_div_i = t.div; cfg_lead_dly_i = t.lead;
      cfg_trail_dly_i = t.trail; cfg_gap_dly_i = t.gap; cfg_frame_len_i = t.len;
      cfg_cont_i = 0;
      exp_per = (t.div + 2) * tk; exp_lead = (t.lead + 1) * tk;
      exp_trail = (t.trail + 1) * tk; exp_gap = (t.gap + 2) * tk;
      slv_load = 32'(t.rx & mask) << (31 - t.len);
      clr();
      push(w1); push(w2); finish_run();
      chk("R2 mosi frame1", mos_prev, 32'(w1));
      chk("R2 mosi frame2", mos_last, 32'(w2));
      chk("R1/R2 rx frame1", rx_prev, t.rx & mask);
      chk("R1/R2 rx frame2", rx_last, t.rx & mask);
      chk("R2 bit count", rise_cnt, 2 * (t.len + 1));
      chk("R3 period", per_bad, 0);
      chk("R4 lead", lead_bad, 0);
      chk("R5 trail", trail_bad, 0);
      chk("R6 gap", gap_bad, 0);
      chk("R7 cs released twice", csr_cnt, 2);
      chk("R9 rx strobes", rxv_cnt, 2);
      chk("R9 rx on rise", rxrise_bad, 0);
      chk("R10 mosi holds", mosi_o, w2[0]);
      chk("R12 idle ready", {busy_o, tx_ready_o}, 2'b01);
    end

    // R8 continuous mode, two back-to-back bytes
    cfg_prescale_i = 0; cfg_sck_div_i = 2; cfg_lead_dly_i = 1; cfg_trail_dly_i = 1;
    cfg_gap_dly_i = 0; cfg_frame_len_i = 7; cfg_cont_i = 1;
    exp_per = 4; exp_lead = 2; exp_trail = 2; exp_gap = 2;
    slv_load = {8'h96, 8'h2D, 16'h0};
    clr();
    push(16'h003C); push(16'h00C5); finish_run();
    chk("R8 one select window", csr_cnt, 1);
    chk("R8 sck rises", rise_cnt, 16);
    chk("R8 mosi stream", mos_last, 32'h3CC5);
    chk("R8 rx first", rx_prev, 16'h0096);
    chk("R8 rx second", rx_last, 16'h002D);
    chk("R8/R3 uniform period", per_bad, 0);
    chk("R9 cont strobes", rxv_cnt, 2);
    chk("R10 mosi holds cont", mosi_o, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule